// File: doc/BRIEF.md
# Rotation Cipher Block Decryptor

This block turns one 64-bit ciphertext block of a 32-bit-word, twelve-round rotation cipher back into plaintext. The block arrives as two words, A and B. The core walks the expanded subkey table from its top entry to entry zero. It performs one half-round per clock: subtract the subkey, rotate right by an amount taken from the other word, then XOR with that other word. Two plain subtractions of the first subkeys finish the block. The result is then offered on the output.

Blocks enter and leave through valid/ready handshakes. The subkey table itself lives outside the block, so an encryption engine can own and share it. Key expansion and chaining modes are not part of this block.

Top module: `rc5_decrypt_core`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. `in_ready` is 1 exactly while no block is being processed or waiting at the output.
- R2: A block is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_valid` with any data while `in_ready` is 0 has no effect on the block in flight or on its result.
- R3: On the clock after a block is taken, `sk_addr` becomes 2*ROUNDS+1 (25). It then falls by one every cycle down to 0. `sk_data` is read combinationally in the same cycle as `sk_addr`.
- R4: `out_valid` rises 2*ROUNDS+2 (26) clock edges after the edge that took the block.
- R5: For rounds i = 12 down to 1, B becomes ((B − S[2i+1]) rotated right by A[4:0]) XOR A, and then A becomes ((A − S[2i]) rotated right by B[4:0]) XOR B, using the new B. After the rounds, B becomes B − S[1] and then A becomes A − S[0]. All subtraction is modulo 2^32, and a rotation by 0 leaves the word unchanged. `out_a`/`out_b` carry the final A/B.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_a` and `out_b` hold steady. `out_ready` while `out_valid` is 0 has no effect.
- R7: On the edge where `out_valid` and `out_ready` are both 1, the output is released, and `in_ready` is 1 in the next cycle.
- R8: Feeding the core the encryption of a plaintext under a table built from any 16-byte key returns that plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ciphertext block offered |
| in_ready | output | 1 | Core idle, block can be taken |
| in_a | input | WORD_W | Ciphertext word A |
| in_b | input | WORD_W | Ciphertext word B |
| out_valid | output | 1 | Plaintext block available |
| out_ready | input | 1 | Consumer takes the plaintext |
| out_a | output | WORD_W | Plaintext word A |
| out_b | output | WORD_W | Plaintext word B |
| sk_addr | output | ADDR_W | Subkey table read address |
| sk_data | input | WORD_W | Subkey word at `sk_addr` |

## Verification
The bench builds the core with its defaults: 32-bit words and 12 rounds. This exercises the full 26-entry downward table walk and every rotation amount from 0 to 31, including the zero-rotation words that the stimulus forces. The reference table is filled both with raw random subkeys and from random 16-byte keys through a behavioural key schedule. Together these reach the round-trip property, the output hold under back-pressure, and the ignored input offers while busy.

// File: rtl/rc5d_pkg.sv
package rc5d_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } rc5d_state_t;

  // which half-step the datapath performs in a given cycle
  typedef enum logic [1:0] {
    STEP_B_ROUND = 2'd0,
    STEP_A_ROUND = 2'd1,
    STEP_B_FINAL = 2'd2,
    STEP_A_FINAL = 2'd3
  } rc5d_step_t;

endpackage

// File: rtl/rc5d_ctrl.sv
module rc5d_ctrl
  import rc5d_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LAST   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              run,
  output logic              accept,
  output logic [ADDR_W-1:0] addr,
  output rc5d_step_t        step
);

  rc5d_state_t state;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign run       = (state == ST_RUN);
  assign accept    = in_ready && in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      addr  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_RUN;
          addr  <= ADDR_W'(LAST);
        end
        ST_RUN: begin
          if (addr == '0) state <= ST_DONE;
          else            addr  <= addr - 1'b1;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (addr >= ADDR_W'(2)) step = addr[0] ? STEP_B_ROUND : STEP_A_ROUND;
    else                    step = addr[0] ? STEP_B_FINAL : STEP_A_FINAL;
  end

endmodule

// File: rtl/rc5d_step.sv
module rc5d_step
  import rc5d_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  rc5d_step_t        step,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [WORD_W-1:0] s,
  output logic [WORD_W-1:0] na,
  output logic [WORD_W-1:0] nb
);

  localparam int SH_W = $clog2(WORD_W);

  function automatic logic [WORD_W-1:0] rot_right(input logic [WORD_W-1:0] x,
                                                  input logic [SH_W-1:0]   n);
    logic [2*WORD_W-1:0] both;
    both = {x, x} >> n;
    return both[WORD_W-1:0];
  endfunction

  // subtract, rotate by the other word, then mix it back in
  function automatic logic [WORD_W-1:0] unround(input logic [WORD_W-1:0] self,
                                                input logic [WORD_W-1:0] other,
                                                input logic [WORD_W-1:0] key);
    return rot_right(self - key, other[SH_W-1:0]) ^ other;
  endfunction

  always_comb begin
    na = a;
    nb = b;
    unique case (step)
      STEP_B_ROUND: nb = unround(b, a, s);
      STEP_A_ROUND: na = unround(a, b, s);
      STEP_B_FINAL: nb = b - s;
      STEP_A_FINAL: na = a - s;
      default: ;
    endcase
  end

endmodule

// File: rtl/rc5_decrypt_core.sv
module rc5_decrypt_core
  import rc5d_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ROUNDS = 12,
  parameter int ADDR_W = $clog2(2*ROUNDS+2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_a,
  output logic [WORD_W-1:0] out_b,
  output logic [ADDR_W-1:0] sk_addr,
  input  logic [WORD_W-1:0] sk_data
);

  localparam int LAST = 2*ROUNDS + 1;

  logic              run;
  logic              accept;
  logic [ADDR_W-1:0] addr;
  rc5d_step_t        step;
  logic [WORD_W-1:0] reg_a, reg_b, next_a, next_b;

  rc5d_ctrl #(.ADDR_W(ADDR_W), .LAST(LAST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .run(run), .accept(accept),
    .addr(addr), .step(step)
  );

  rc5d_step #(.WORD_W(WORD_W)) u_step (
    .step(step), .a(reg_a), .b(reg_b), .s(sk_data), .na(next_a), .nb(next_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
    end else if (accept) begin
      reg_a <= in_a;
      reg_b <= in_b;
    end else if (run) begin
      reg_a <= next_a;
      reg_b <= next_b;
    end
  end

  assign sk_addr = run ? addr : '0;
  assign out_a   = reg_a;
  assign out_b   = reg_b;

endmodule

// File: rtl/rc5d_checker.sv
module rc5d_checker #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 5,
  parameter int LAST   = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_a,
  input logic [WORD_W-1:0] out_b,
  input logic [ADDR_W-1:0] sk_addr,
  input logic              run,
  input logic              accept
);

  a_r1_ready_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  a_r3_walk_start: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (run && sk_addr == ADDR_W'(LAST)));

  a_r3_walk_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sk_addr != '0) |=> (run && sk_addr == $past(sk_addr) - 1'b1));

  a_r4_done_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sk_addr == '0) |=> out_valid);

  a_r6_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_a) && $stable(out_b)));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

endmodule

bind rc5_decrypt_core rc5d_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .LAST(LAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_a(out_a), .out_b(out_b), .sk_addr(sk_addr),
  .run(run), .accept(accept)
);

// File: tb/rc5_decrypt_core_bench.sv
module rc5_decrypt_core_bench;

  localparam int W = 32;
  localparam int R = 12;
  localparam int T = 2*R + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_a, out_b;
  logic [4:0]  sk_addr;
  logic [31:0] sk_data;
  logic [31:0] S [0:T-1];

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string data_tag = "R5";

  always #4 clk = ~clk;

  assign sk_data = (sk_addr < 5'(T)) ? S[sk_addr] : 32'h0;

  rc5_decrypt_core u_rc5_decrypt_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_a(out_a), .out_b(out_b), .sk_addr(sk_addr), .sk_data(sk_data)
  );

  function automatic logic [31:0] rol(input logic [31:0] x, input int n);
    logic [63:0] t;
    t = {x, x} << (n % 32);
    return t[63:32];
  endfunction

  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    return rol(x, (32 - (n % 32)) % 32);
  endfunction

  function automatic logic [63:0] ref_dec(input logic [31:0] a0, input logic [31:0] b0);
    logic [31:0] a, b;
    a = a0; b = b0;
    for (int i = R; i >= 1; i--) begin
      b = ror(b - S[2*i+1], int'(a[4:0])) ^ a;
      a = ror(a - S[2*i], int'(b[4:0])) ^ b;
    end
    b = b - S[1];
    a = a - S[0];
    return {a, b};
  endfunction

  function automatic logic [63:0] ref_enc(input logic [31:0] a0, input logic [31:0] b0);
    logic [31:0] a, b;
    a = a0 + S[0]; b = b0 + S[1];
    for (int i = 1; i <= R; i++) begin
      a = rol(a ^ b, int'(b[4:0])) + S[2*i];
      b = rol(b ^ a, int'(a[4:0])) + S[2*i+1];
    end
    return {a, b};
  endfunction

  task automatic expand_key(input logic [31:0] k0, k1, k2, k3);
    logic [31:0] L [0:3];
    logic [31:0] a, b;
    int i, j;
    L[0] = k0; L[1] = k1; L[2] = k2; L[3] = k3;
    S[0] = 32'hB7E15163;
    for (int n = 1; n < T; n++) S[n] = S[n-1] + 32'h9E3779B9;
    a = 0; b = 0; i = 0; j = 0;
    for (int n = 0; n < 3*T; n++) begin
      a = rol(S[i] + a + b, 3);
      S[i] = a;
      b = rol(L[j] + a + b, int'(a + b) % 32);
      L[j] = b;
      i = (i + 1) % T;
      j = (j + 1) % 4;
    end
  endtask

  task automatic random_table();
    for (int n = 0; n < T; n++) S[n] = $urandom;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 working, 2 holding result
  int          m_state = 0;
  int          m_count = 0;
  logic [63:0] m_result = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0;
      m_count = 0;
    end else begin
      if (m_state == 0) begin
        if (in_valid) begin
          m_result = ref_dec(in_a, in_b);
          m_state = 1;
          m_count = T - 1;
        end
      end else if (m_state == 1) begin
        if (m_count == 0) m_state = 2;
        else m_count--;
      end else if (out_ready) begin
        m_state = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R1,R7 in_ready", 64'(in_ready), 64'(m_state == 0));
      check("R4,R6 out_valid", 64'(out_valid), 64'(m_state == 2));
      if (m_state == 1) check("R3 sk_addr", 64'(sk_addr), 64'(m_count));
      if (m_state == 2) check({data_tag, " data"}, {out_a, out_b}, m_result);
    end
  end

  task automatic send(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(input int hold, output logic [63:0] got);
    while (!out_valid) @(negedge clk);
    repeat (hold) @(negedge clk);
    got = {out_a, out_b};
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    logic [63:0] got, pt, ct;
    random_table();
    repeat (3) @(negedge clk);
    check("R1 reset in_ready", 64'(in_ready), 64'd1);
    check("R1 reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;

    // plain blocks, consumer always ready
    data_tag = "R5";
    for (int n = 0; n < 4; n++) begin
      send($urandom, $urandom);
      collect(0, got);
    end
    // zero-rotation and all-ones corners
    send(32'h0, 32'h0);              collect(0, got);
    send(32'hFFFF_FFE0, 32'h1234_5600); collect(0, got);
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF); collect(0, got);

    // back-pressure with stray input offers while busy
    data_tag = "R2,R6";
    send(32'hCAFE_0001, 32'h0BAD_F00D);
    repeat (4) @(negedge clk);
    in_valid = 1'b1; in_a = 32'h5555_AAAA; in_b = 32'h1357_9BDF;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    collect(7, got);
    check("R2 result kept", got, ref_dec(32'hCAFE_0001, 32'h0BAD_F00D));

    // output-ready pulse while idle has no effect
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    out_ready = 1'b0;
    check("R6 idle out_valid", 64'(out_valid), 64'd0);

    // round trip through freshly expanded keys
    data_tag = "R8,R5";
    for (int k = 0; k < 4; k++) begin
      expand_key($urandom, $urandom, $urandom, $urandom);
      pt = {$urandom, $urandom};
      ct = ref_enc(pt[63:32], pt[31:0]);
      send(ct[63:32], ct[31:0]);
      collect(k, got);
      check("R8 round trip", got, pt);
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule